// File: doc/BRIEF.md
# Pixel Unpacker with Palette Lookup

This block sits between a display line buffer and an LCD panel driver. It takes 32-bit words of display memory through a ready/valid handshake and splits each word into packed pixel codes. It emits one 18-bit RGB pixel per clock, with a valid strobe and a ready input for backpressure. Eight pixel formats share one datapath:

- four grayscale depths (1, 2, 4 and 6 bits);
- two indexed color depths (4 and 8 bits) that read a 256-entry palette RAM;
- two direct color depths (15 and 16 bits) that are decoded without any lookup.

Configuration inputs control three things. The first is whether the four bytes of an incoming word are reversed before unpacking. The second is whether pixels are taken from the low or the high end of a word. The third is whether all 18 output bits are inverted to match the panel polarity. A processor-side write port fills the palette. Each palette entry is 24 bits wide, and only a red-green-blue subset of 5, 6 and 5 bits is used. Configuration is expected to change only while the block is empty.

Top module: `pix_unpack_lut`

## Requirements
- R1: `cfg_mode` selects the depth: 0 gray 1 bpp, 1 gray 2 bpp, 2 gray 4 bpp, 3 gray 6 bpp, 4 palette 4 bpp, 5 palette 8 bpp, 6 direct 15 bpp, 7 direct 16 bpp. A word holds floor(32/bpp) pixels. With `cfg_msb_first`=0, pixel k occupies bits [k*bpp +: bpp]. Bits above the last whole pixel are discarded, and no pixel spans two words.
- R2: With `cfg_msb_first`=1, the used bits are the same, but the order is reversed: the first pixel comes from the highest used position.
- R3: With `cfg_swap_bytes`=1, byte lane i of `in_word` is moved to lane 3-i before pixels are extracted.
- R4: In modes 4 and 5, the code indexes the palette. Red is entry bits [23:19], green is [15:10] and blue is [7:3]. All other entry bits have no effect on the output.
- R5: Mode 6 decodes the code as red [14:10], green [9:5] and blue [4:0].
- R6: Mode 7 decodes the code as red [15:11], green [10:5] and blue [4:0].
- R7: In grayscale modes, the code is widened to 6 bits by repeating its bit pattern from the MSB down. The result drives red, green and blue equally.
- R8: Every 5-bit channel is widened to 6 bits by appending a copy of its MSB. `out_rgb` is {red[5:0], green[5:0], blue[5:0]}.
- R9: With `cfg_invert`=1, all 18 bits of `out_rgb` are inverted.
- R10: If `out_ready` stays high, the first pixel of a word accepted at clock edge n becomes valid after edge n+1. `out_valid` is never high before any word has been accepted.
- R11: While `out_valid` is high and `out_ready` is low, `out_rgb` and `out_valid` hold their values. `in_ready` stays low until the last pixel of the held word advances. No pixel is lost or repeated.
- R12: After reset, `out_valid` is 0 and `in_ready` is 1.
- R13: A palette write at a clock edge is seen by every pixel extracted after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 3 | Pixel format select (see R1) |
| cfg_msb_first | input | 1 | Take pixels from the high end of the word first |
| cfg_swap_bytes | input | 1 | Reverse byte lanes of each input word |
| cfg_invert | input | 1 | Invert all output data bits |
| in_word | input | 32 | Display memory word |
| in_valid | input | 1 | `in_word` is valid |
| in_ready | output | 1 | Block accepts `in_word` at this edge |
| pal_we | input | 1 | Palette write enable |
| pal_addr | input | 8 | Palette write address |
| pal_wdata | input | 24 | Palette write data |
| out_rgb | output | 18 | Pixel, red/green/blue 6 bits each |
| out_valid | output | 1 | `out_rgb` is valid |
| out_ready | input | 1 | Downstream accepts the pixel |

## Verification
The hardest case to reach is a stall that arrives in the middle of a word, while the next word is already waiting at the input. This matters most in the modes where top bits are discarded and pixels are taken from the high end first. Random stimulus drops `out_ready` on about a quarter of the cycles and holds `in_valid` across refusals, for every mode and ordering combination. A directed case holds the output stalled for several cycles with a second word pending, then releases it and counts every pixel against a reference queue.

// File: rtl/pxu_pkg.sv
// Shared types for the pixel unpacker: format codes and palette entry layout.
// Assumes a fixed 8-mode encoding that software writes directly.
package pxu_pkg;

    typedef enum logic [2:0] {
        MODE_G1  = 3'd0,
        MODE_G2  = 3'd1,
        MODE_G4  = 3'd2,
        MODE_G6  = 3'd3,
        MODE_P4  = 3'd4,
        MODE_P8  = 3'd5,
        MODE_D15 = 3'd6,
        MODE_D16 = 3'd7
    } pix_mode_e;

    // Most significant bit of each colour field inside a 24-bit palette entry
    localparam int PAL_R_HI = 23;
    localparam int PAL_G_HI = 15;
    localparam int PAL_B_HI = 7;

    // Bits per pixel for each format
    function automatic int bpp_of(pix_mode_e m);
        case (m)
            MODE_G1:  return 1;
            MODE_G2:  return 2;
            MODE_G4:  return 4;
            MODE_G6:  return 6;
            MODE_P4:  return 4;
            MODE_P8:  return 8;
            MODE_D15: return 15;
            default:  return 16;
        endcase
    endfunction

endpackage

// File: rtl/pxu_word_unpack.sv
// Holds one input word and hands out its packed pixel codes one at a time.
// Assumes mode, order and swap stay constant while a word is held.
// A pixel is consumed in each cycle where code_valid and advance are both high.
module pxu_word_unpack
    import pxu_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int CODE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pix_mode_e         mode,
    input  logic              msb_first,
    input  logic              swap_bytes,
    input  logic [WORD_W-1:0] in_word,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              advance,
    output logic              code_valid,
    output logic [CODE_W-1:0] code
);

    localparam int LANES = WORD_W / 8;
    localparam int IDX_W = $clog2(WORD_W) + 1;

    logic [WORD_W-1:0] lane_word;
    logic [WORD_W-1:0] w_data;
    logic              w_valid;
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] shifted;
    logic [CODE_W-1:0] mask;
    logic              last;
    int                bpp;
    int                ppw;
    int                sh;

    // Byte-lane reversal of the incoming word
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_word[g*8 +: 8] = swap_bytes ? in_word[(LANES-1-g)*8 +: 8]
                                                : in_word[g*8 +: 8];
    end

    // Pixel geometry and the bit offset of the current pixel
    always_comb begin
        bpp  = bpp_of(mode);
        ppw  = WORD_W / bpp;
        last = (int'(idx) == ppw - 1);
        sh   = msb_first ? (ppw - 1 - int'(idx)) * bpp : int'(idx) * bpp;
    end

    // Extract the current code from the held word
    always_comb begin
        shifted = w_data >> sh;
        mask    = CODE_W'((32'd1 << bpp) - 32'd1);
        code    = shifted[CODE_W-1:0] & mask;
    end

    assign code_valid = w_valid;
    assign in_ready   = !w_valid || (advance && last);

    // Word register and pixel index; a new word takes over once the last pixel leaves
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_valid <= 1'b0;
            w_data  <= '0;
            idx     <= '0;
        end else begin
            if (w_valid && advance) begin
                idx <= idx + 1'b1;
                if (last) begin
                    w_valid <= 1'b0;
                end
            end
            if (in_valid && in_ready) begin
                w_valid <= 1'b1;
                w_data  <= lane_word;
                idx     <= '0;
            end
        end
    end

    logic unused_hi;
    assign unused_hi = ^shifted[WORD_W-1:CODE_W];

endmodule

// File: rtl/pxu_palette_ram.sv
// Palette storage: one write port and one registered read port.
// A read and a write to the same address in one cycle return the old entry.
// The read port keeps its output while re is low, so a stalled pixel is not disturbed.
module pxu_palette_ram #(
    parameter int AW = 8,
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Processor-side write
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Registered read for the pixel pipeline
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/pxu_color_map.sv
// Turns a pixel code, or a palette entry, into 18-bit RGB and applies the polarity.
// Purely combinational; the caller registers code, mode and palette data.
module pxu_color_map
    import pxu_pkg::*;
#(
    parameter int CODE_W = 16,
    parameter int PAL_DW = 24
) (
    input  pix_mode_e         mode,
    input  logic [CODE_W-1:0] code,
    input  logic [PAL_DW-1:0] pal_entry,
    input  logic              invert,
    output logic [17:0]       rgb
);

    logic [5:0] r6;
    logic [5:0] g6;
    logic [5:0] b6;

    function automatic logic [5:0] widen5(logic [4:0] v);
        return {v, v[4]};
    endfunction

    // Per-format decode into three 6-bit channels
    always_comb begin
        r6 = '0;
        g6 = '0;
        b6 = '0;
        case (mode)
            MODE_G1: r6 = {6{code[0]}};
            MODE_G2: r6 = {3{code[1:0]}};
            MODE_G4: r6 = {code[3:0], code[3:2]};
            MODE_G6: r6 = code[5:0];
            MODE_P4, MODE_P8: begin
                r6 = widen5(pal_entry[PAL_R_HI -: 5]);
                g6 = pal_entry[PAL_G_HI -: 6];
                b6 = widen5(pal_entry[PAL_B_HI -: 5]);
            end
            MODE_D15: begin
                r6 = widen5(code[14:10]);
                g6 = widen5(code[9:5]);
                b6 = widen5(code[4:0]);
            end
            default: begin
                r6 = widen5(code[15:11]);
                g6 = code[10:5];
                b6 = widen5(code[4:0]);
            end
        endcase
        if (mode inside {MODE_G1, MODE_G2, MODE_G4, MODE_G6}) begin
            g6 = r6;
            b6 = r6;
        end
    end

    assign rgb = {r6, g6, b6} ^ {18{invert}};

    logic unused_pal;
    assign unused_pal = ^{pal_entry[18:16], pal_entry[9:8], pal_entry[2:0]};

endmodule

// File: rtl/pix_unpack_lut.sv
// Top of the pixel unpacker. The pipeline has two stages:
//   word stage   - holds a word and selects one pixel code per cycle
//   output stage - holds the code, the mode and the registered palette entry
// Every format takes the same one-cycle latency, so the palette lookup and
// the direct formats stay aligned. Configuration must be static while busy.
module pix_unpack_lut
    import pxu_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int PAL_AW = 8,
    parameter int PAL_DW = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_mode,
    input  logic              cfg_msb_first,
    input  logic              cfg_swap_bytes,
    input  logic              cfg_invert,
    input  logic [WORD_W-1:0] in_word,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              pal_we,
    input  logic [PAL_AW-1:0] pal_addr,
    input  logic [PAL_DW-1:0] pal_wdata,
    output logic [17:0]       out_rgb,
    output logic              out_valid,
    input  logic              out_ready
);

    localparam int CODE_W = 16;

    pix_mode_e         mode;
    logic              advance;
    logic              code_valid;
    logic [CODE_W-1:0] code;
    logic              take;
    logic              s1_valid;
    logic [CODE_W-1:0] s1_code;
    pix_mode_e         s1_mode;
    logic [PAL_DW-1:0] pal_entry;

    assign mode    = pix_mode_e'(cfg_mode);
    assign advance = !s1_valid || out_ready;
    assign take    = code_valid && advance;

    pxu_word_unpack #(
        .WORD_W(WORD_W),
        .CODE_W(CODE_W)
    ) u_unpack (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .msb_first (cfg_msb_first),
        .swap_bytes(cfg_swap_bytes),
        .in_word   (in_word),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .advance   (advance),
        .code_valid(code_valid),
        .code      (code)
    );

    pxu_palette_ram #(
        .AW(PAL_AW),
        .DW(PAL_DW)
    ) u_pal (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (pal_we),
        .waddr(pal_addr),
        .wdata(pal_wdata),
        .re   (take),
        .raddr(code[PAL_AW-1:0]),
        .rdata(pal_entry)
    );

    // Output stage registers, aligned with the palette read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_code  <= '0;
            s1_mode  <= MODE_G1;
        end else if (advance) begin
            s1_valid <= code_valid;
            if (code_valid) begin
                s1_code <= code;
                s1_mode <= mode;
            end
        end
    end

    pxu_color_map #(
        .CODE_W(CODE_W),
        .PAL_DW(PAL_DW)
    ) u_map (
        .mode     (s1_mode),
        .code     (s1_code),
        .pal_entry(pal_entry),
        .invert   (cfg_invert),
        .rgb      (out_rgb)
    );

    assign out_valid = s1_valid;

endmodule

// File: rtl/pxu_checker.sv
// Port-level properties of the pixel unpacker, bound to every instance of the top.
module pxu_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  cfg_mode,
    input logic        in_valid,
    input logic        in_ready,
    input logic [17:0] out_rgb,
    input logic        out_valid,
    input logic        out_ready
);

    logic seen_word;

    // Remember whether any word has been accepted since reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_word <= 1'b0;
        end else if (in_valid && in_ready) begin
            seen_word <= 1'b1;
        end
    end

    assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_word |-> !out_valid);

    assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_rgb)));

    assert_gray_equal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cfg_mode < 3'd4) |->
            (out_rgb[17:12] == out_rgb[11:6] && out_rgb[11:6] == out_rgb[5:0]));

    assert_widen_msb_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cfg_mode >= 3'd6) |->
            (out_rgb[17] == out_rgb[12] && out_rgb[5] == out_rgb[0]));

endmodule

bind pix_unpack_lut pxu_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_mode (cfg_mode),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .out_rgb  (out_rgb),
    .out_valid(out_valid),
    .out_ready(out_ready)
);

// File: tb/pix_unpack_lut_tb.sv
// Bench: directed corners plus seeded random traffic, checked against a reference queue.
module pix_unpack_lut_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  cfg_mode;
    logic        cfg_msb_first;
    logic        cfg_swap_bytes;
    logic        cfg_invert;
    logic [31:0] in_word;
    logic        in_valid;
    logic        in_ready;
    logic        pal_we;
    logic [7:0]  pal_addr;
    logic [23:0] pal_wdata;
    logic [17:0] out_rgb;
    logic        out_valid;
    logic        out_ready;

    always #5 clk = ~clk;

    pix_unpack_lut u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_mode      (cfg_mode),
        .cfg_msb_first (cfg_msb_first),
        .cfg_swap_bytes(cfg_swap_bytes),
        .cfg_invert    (cfg_invert),
        .in_word       (in_word),
        .in_valid      (in_valid),
        .in_ready      (in_ready),
        .pal_we        (pal_we),
        .pal_addr      (pal_addr),
        .pal_wdata     (pal_wdata),
        .out_rgb       (out_rgb),
        .out_valid     (out_valid),
        .out_ready     (out_ready)
    );

    int          checks = 0;
    int          errors = 0;
    bit          done = 0;
    bit          fired_in = 0;
    string       mtag = "";
    logic [17:0] exp_q[$];
    logic [23:0] pal_m [256];

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int bpp_b(int m);
        case (m)
            0: return 1;
            1: return 2;
            2: return 4;
            3: return 6;
            4: return 4;
            5: return 8;
            6: return 15;
            default: return 16;
        endcase
    endfunction

    // Reference pixel k of a word, from R1 to R9
    function automatic logic [17:0] exp_pix(int m, logic [31:0] w, int k,
                                            bit msb, bit swp, bit inv);
        int          b = bpp_b(m);
        int          n = 32 / b;
        int          pos;
        logic [31:0] c;
        logic [23:0] e;
        logic [4:0]  r5, b5, g5;
        logic [5:0]  r6, g6, b6;
        if (swp) w = {w[7:0], w[15:8], w[23:16], w[31:24]};       // R3
        pos = msb ? (n - 1 - k) : k;                               // R1, R2
        c = (w >> (pos * b)) & ((32'd1 << b) - 32'd1);
        if (m < 4) begin                                           // R7
            for (int i = 0; i < 6; i++) g6[5-i] = c[b - 1 - (i % b)];
            r6 = g6;
            b6 = g6;
        end else if (m < 6) begin                                  // R4
            e  = pal_m[c[7:0]];
            r5 = e[23:19];
            g6 = e[15:10];
            b5 = e[7:3];
            r6 = {r5, r5[4]};                                      // R8
            b6 = {b5, b5[4]};
        end else if (m == 6) begin                                 // R5
            r5 = c[14:10];
            g5 = c[9:5];
            b5 = c[4:0];
            r6 = {r5, r5[4]};
            g6 = {g5, g5[4]};
            b6 = {b5, b5[4]};
        end else begin                                             // R6
            r5 = c[15:11];
            g6 = c[10:5];
            b5 = c[4:0];
            r6 = {r5, r5[4]};
            b6 = {b5, b5[4]};
        end
        return {r6, g6, b6} ^ {18{inv}};                           // R9
    endfunction

    // Record the handshakes of the coming edge, then move to the next falling edge
    task automatic tick();
        logic [17:0] e;
        #1;
        fired_in = in_valid && in_ready;
        if (fired_in) begin
            for (int k = 0; k < 32 / bpp_b(int'(cfg_mode)); k++)
                exp_q.push_back(exp_pix(int'(cfg_mode), in_word, k,
                                        cfg_msb_first, cfg_swap_bytes, cfg_invert));
        end
        if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, {mtag, " unexpected pixel"}, 32'(out_rgb), 32'd0);
            end else begin
                e = exp_q.pop_front();
                check(out_rgb == e, mtag, 32'(out_rgb), 32'(e));
            end
        end
        @(negedge clk);
    endtask

    task automatic set_mode(int m, bit msb, bit swp, bit inv);
        cfg_mode       = 3'(m);
        cfg_msb_first  = msb;
        cfg_swap_bytes = swp;
        cfg_invert     = inv;
        if (m < 4)       mtag = "R7";
        else if (m < 6)  mtag = "R4 R13";
        else if (m == 6) mtag = "R5";
        else             mtag = "R6";
        mtag = {mtag, " with R1 R2 R3 R8 R9"};
    endtask

    task automatic drain();
        in_valid  = 1'b0;
        out_ready = 1'b1;
        repeat (40) tick();
        check(exp_q.size() == 0, "R11 pixels missing after drain", exp_q.size(), 0);
        check(!out_valid, "R11 output idle after drain", 32'(out_valid), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [17:0] held;
        int          sent;
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        in_valid = 1'b0;
        in_word = '0;
        out_ready = 1'b0;
        pal_we = 1'b0;
        pal_addr = '0;
        pal_wdata = '0;
        set_mode(0, 1'b0, 1'b0, 1'b0);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R12 in_ready after reset", 32'(in_ready), 1);
        check(out_valid == 1'b0, "R12 out_valid after reset", 32'(out_valid), 0);

        // Fill the palette with random 24-bit entries
        for (int a = 0; a < 256; a++) begin
            pal_we = 1'b1;
            pal_addr = 8'(a);
            pal_wdata = 24'($urandom);
            pal_m[a] = pal_wdata;
            @(negedge clk);
        end
        pal_we = 1'b0;

        // R10: latency of the first pixel
        set_mode(7, 1'b0, 1'b0, 1'b0);
        in_word = 32'h1234_abcd;
        in_valid = 1'b1;
        out_ready = 1'b1;
        tick();
        in_valid = 1'b0;
        check(out_valid == 1'b0, "R10 output one edge after accept", 32'(out_valid), 0);
        tick();
        check(out_valid == 1'b1, "R10 output two edges after accept", 32'(out_valid), 1);
        drain();

        // R11: long stall with a second word waiting
        set_mode(0, 1'b1, 1'b0, 1'b0);
        in_word = 32'h8000_0001;
        in_valid = 1'b1;
        out_ready = 1'b0;
        tick();
        in_word = 32'h0f0f_3c3c;
        repeat (2) tick();
        check(out_valid == 1'b1, "R11 pixel presented under stall", 32'(out_valid), 1);
        held = out_rgb;
        repeat (6) tick();
        check(out_valid && out_rgb == held, "R11 pixel held under stall", 32'(out_rgb), 32'(held));
        check(!in_ready, "R11 in_ready low mid-word", 32'(in_ready), 0);
        out_ready = 1'b1;
        fired_in = 1'b0;
        while (!fired_in) tick();
        in_valid = 1'b0;
        drain();

        // R13: a rewritten palette entry is used by later pixels
        pal_we = 1'b1;
        pal_addr = 8'd5;
        pal_wdata = 24'ha5_5a_c3;
        pal_m[5] = pal_wdata;
        @(negedge clk);
        pal_we = 1'b0;
        set_mode(4, 1'b0, 1'b0, 1'b1);
        in_word = 32'h5555_5555;
        in_valid = 1'b1;
        out_ready = 1'b1;
        tick();
        in_valid = 1'b0;
        drain();

        // Random traffic over every mode, order and swap combination
        for (int m = 0; m < 8; m++) begin
            for (int c = 0; c < 4; c++) begin
                set_mode(m, c[0], c[1], 1'($urandom));
                sent = 0;
                fired_in = 1'b0;
                in_valid = 1'b0;
                while (sent < 16) begin
                    if (!in_valid || fired_in) begin
                        int r = int'($urandom % 8);
                        in_valid = ($urandom % 4) != 0;
                        in_word  = (r == 0) ? 32'h0 : (r == 1) ? 32'hffff_ffff : $urandom;
                    end
                    out_ready = ($urandom % 4) != 0;
                    tick();
                    if (fired_in) sent++;
                end
                drain();
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule